// File: doc/BRIEF.md
# Transmit Retry Limit Controller

This block decides, for three outbound asynchronous transmit units, whether a packet that the target did not accept is sent again or abandoned. Software programs one 4-bit retry limit per unit through a single 32-bit limits register. Unit 0 is the request DMA transmitter, unit 1 the response transmitter and unit 2 the physical response unit.

Each unit keeps its own attempt counter. When a transmission finishes, the unit's done strobe and acknowledge code come in. If the target reported busy or a data error and the counter is still below the limit, the block pulses that unit's retry output. Once the counter has reached the limit, it pulses give-up instead. Any other acknowledge closes the packet without either pulse. The upper register bits belong to a dual-phase retry scheme that is not built, so they always read as zero.

Top module: `retry_limit_ctrl`

## Requirements
- R1: The limits register sits at address 8'h08. Bits 3:0 hold the unit 0 limit, bits 7:4 the unit 1 limit and bits 11:8 the unit 2 limit. A write to that address stores bits 11:0, and a read returns them.
- R2: Bits 31:12 of the register always read 0, even after a write of all ones. A read of any other address returns 0.
- R3: After reset, the register reads 32'h0000_0000 and every retry and give-up output is low.
- R4: Only the acknowledge codes 4'h4 (busy) and 4'hD (data error) are retryable. When a unit's done strobe comes with a retryable code and its attempt count is below its limit, that unit's retry output is high for exactly the next cycle and its count goes up by one.
- R5: When a retryable acknowledge arrives and the count has already reached the limit, give-up is high for exactly the next cycle and the count clears. A limit of 0 therefore gives up on the first retryable acknowledge. A limit of 15 gives 15 retries followed by give-up, which is 16 attempts in total.
- R6: A done strobe with any other acknowledge code produces neither retry nor give-up and clears that unit's count.
- R7: A unit's packet-start strobe clears that unit's count.
- R8: A change to a limit while a packet is in flight applies from the next retry decision onward.
- R9: The units are independent. Each unit's outputs depend only on that unit's strobes, acknowledge code and limit field.
- R10: Retry and give-up are never high together for the same unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pkt_start | input | 3 | Per-unit new-packet strobe |
| tx_done | input | 3 | Per-unit transmission-finished strobe |
| tx_ack | input | 12 | Per-unit 4-bit acknowledge code, unit u at bits 4u+3:4u |
| retry | output | 3 | Per-unit resend pulse |
| give_up | output | 3 | Per-unit abandon pulse |

## Verification
The bench uses the default build: three units, 4-bit limits and 4-bit acknowledge codes. With these settings the full limit range of 0 through 15 on every unit can be swept exhaustively. For each unit and each limit, the bench runs the complete retry sequence, alternating busy and data-error acknowledges, while the other two units hold different limits. This drives both limit corners: immediate give-up at 0 and sixteen attempts at 15. Directed sequences then cover the interleaved non-retryable acknowledge, a restart in mid-packet, a limit change in mid-packet, and reads of the zero bits.

// File: rtl/retry_limit_ctrl.sv
module retry_limit_ctrl #(
  parameter int NUNITS = 3,
  parameter int LIM_W = 4,
  parameter int ACK_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h08,
  parameter logic [ACK_W-1:0] ACK_BUSY = 4'h4,
  parameter logic [ACK_W-1:0] ACK_DERR = 4'hD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUNITS-1:0]       pkt_start,
  input  logic [NUNITS-1:0]       tx_done,
  input  logic [NUNITS*ACK_W-1:0] tx_ack,
  output logic [NUNITS-1:0]       retry,
  output logic [NUNITS-1:0]       give_up
);
  localparam int LIM_BITS = NUNITS * LIM_W;

  logic [LIM_BITS-1:0] limits;
  logic [LIM_BITS-1:0] cnt_flat;

  wire sel = (reg_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)            limits <= '0;
    else if (reg_wr && sel) limits <= reg_wdata[LIM_BITS-1:0];
  end

  assign reg_rdata = sel ? 32'(limits) : 32'h0;

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    wire [LIM_W-1:0] lim = limits[u*LIM_W +: LIM_W];
    wire [ACK_W-1:0] ack = tx_ack[u*ACK_W +: ACK_W];
    wire retryable = (ack == ACK_BUSY) || (ack == ACK_DERR);
    logic [LIM_W-1:0] cnt;
    wire exhausted = (cnt >= lim);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        retry[u] <= 1'b0;
        give_up[u] <= 1'b0;
      end else begin
        retry[u]   <= tx_done[u] && retryable && !exhausted;
        give_up[u] <= tx_done[u] && retryable && exhausted;
        if (pkt_start[u])   cnt <= '0;
        else if (tx_done[u]) cnt <= (retryable && !exhausted) ? cnt + 1'b1 : '0;
      end
    end

    assign cnt_flat[u*LIM_W +: LIM_W] = cnt;
  end
endmodule

// File: rtl/retry_limit_ctrl_chk.sv
module retry_limit_ctrl_chk #(
  parameter int NUNITS = 3,
  parameter int LIM_W = 4,
  parameter int ACK_W = 4,
  parameter logic [ACK_W-1:0] ACK_BUSY = 4'h4,
  parameter logic [ACK_W-1:0] ACK_DERR = 4'hD
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [31:0]             reg_rdata,
  input logic [NUNITS-1:0]       tx_done,
  input logic [NUNITS*ACK_W-1:0] tx_ack,
  input logic [NUNITS-1:0]       retry,
  input logic [NUNITS-1:0]       give_up,
  input logic [NUNITS*LIM_W-1:0] cnt_flat
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:NUNITS*LIM_W] == '0);

  for (genvar u = 0; u < NUNITS; u++) begin : g_chk
    wire [ACK_W-1:0] ack = tx_ack[u*ACK_W +: ACK_W];
    wire rtr = (ack == ACK_BUSY) || (ack == ACK_DERR);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(retry[u] && give_up[u]));

    a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (retry[u] || give_up[u]) |-> ($past(tx_done[u]) && $past(rtr)));

    a_r6_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done[u] && !rtr) |=> (!retry[u] && !give_up[u]));

    a_r5_clear_on_giveup: assert property (@(posedge clk) disable iff (!rst_n)
      give_up[u] |-> (cnt_flat[u*LIM_W +: LIM_W] == '0));

    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      retry[u] |-> (cnt_flat[u*LIM_W +: LIM_W] != '0));
  end
endmodule

bind retry_limit_ctrl retry_limit_ctrl_chk #(
  .NUNITS(NUNITS), .LIM_W(LIM_W), .ACK_W(ACK_W),
  .ACK_BUSY(ACK_BUSY), .ACK_DERR(ACK_DERR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .tx_done(tx_done),
  .tx_ack(tx_ack), .retry(retry), .give_up(give_up), .cnt_flat(cnt_flat)
);

// File: tb/retry_limit_ctrl_bench.sv
`timescale 1ns/1ps
module retry_limit_ctrl_bench;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_addr = 8'h08;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [2:0] pkt_start = 0, tx_done = 0, retry, give_up;
  logic [11:0] tx_ack = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  retry_limit_ctrl u_retry_limit_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_start(pkt_start),
    .tx_done(tx_done), .tx_ack(tx_ack), .retry(retry), .give_up(give_up));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h08;
  endtask

  task automatic start(int u);
    @(negedge clk); pkt_start[u] = 1;
    @(negedge clk); pkt_start = 0;
  endtask

  task automatic send(int u, logic [3:0] a, string req, logic exp_r, logic exp_g);
    @(negedge clk); tx_done[u] = 1; tx_ack[u*4 +: 4] = a;
    @(negedge clk); tx_done = 0;
    check(req, {26'b0, retry, give_up}, {26'b0, 3'(exp_r) << u, 3'(exp_g) << u});
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset read", reg_rdata, 32'h0);
    check("R3 reset outputs", {26'b0, retry, give_up}, 32'h0);
    rst_n = 1;

    wr(8'h08, 32'hFFFF_FFFF);
    check("R2 upper bits zero", reg_rdata, 32'h0000_0FFF);
    reg_addr = 8'h0C; #1;
    check("R2 other address", reg_rdata, 32'h0);
    reg_addr = 8'h08;

    for (int u = 0; u < 3; u++) begin
      for (int lim = 0; lim < 16; lim++) begin
        logic [11:0] v;
        v = {3{4'(15 - lim)}};
        v[u*4 +: 4] = 4'(lim);
        wr(8'h08, {20'b0, v});
        check("R1 readback", reg_rdata, {20'b0, v});
        start(u);
        for (int k = 0; k <= lim; k++)
          send(u, k[0] ? 4'hD : 4'h4, "R4 R5 R9 sweep", k < lim, k == lim);
      end
    end

    wr(8'h08, 32'h0000_0333);
    start(1);
    send(1, 4'h4, "R4 pre", 1, 0);
    send(1, 4'h4, "R4 pre", 1, 0);
    send(1, 4'h1, "R6 non-retryable", 0, 0);
    for (int k = 0; k < 3; k++) send(1, 4'hD, "R6 count cleared", 1, 0);
    send(1, 4'h4, "R6 give-up after clear", 0, 1);

    start(2);
    send(2, 4'h4, "R7 pre", 1, 0);
    send(2, 4'h4, "R7 pre", 1, 0);
    start(2);
    for (int k = 0; k < 3; k++) send(2, 4'h4, "R7 restart", 1, 0);
    send(2, 4'h4, "R7 give-up", 0, 1);

    wr(8'h08, 32'h0000_0005);
    start(0);
    send(0, 4'h4, "R8 pre", 1, 0);
    send(0, 4'h4, "R8 pre", 1, 0);
    wr(8'h08, 32'h0000_0002);
    send(0, 4'h4, "R8 new limit applies", 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule